// File: doc/BRIEF.md
# Left-Justified Stereo Serial Audio Receiver

This block turns a three-wire stereo serial audio stream into parallel sample words. The stream has a data line, a bit clock and a frame (channel-select) line. Each word is carried in left-justified form: its most significant bit is the first bit after every frame-line transition. The receiver runs on one system clock and samples all three serial lines through a synchronizer. Every completed word is presented as a 24-bit left-aligned value with a channel flag and a one-cycle valid strobe.

The bit clock comes from one of two places. In external mode it is the incoming bit-clock line, sampled on its rising edges. In internal mode the block derives its own bit-sample points from a master-clock enable divided by eight. The divider is realigned at every frame transition. The bits per channel half then follow from the master-clock-to-frame ratio code supplied from outside: 16, 24 or 32 bits for ratios 256, 384 and 512. Any word shorter than 24 bits is padded with zeros on the LSB side, and bits past the 24th are dropped.

Top module: `lrj_rx`

## Requirements
- R1: While reset is asserted and directly after its release, `word_valid` is 0, `word_data` is 0 and `word_chan` is 0.
- R2: In external mode (`mode_ext`=1), `sdata_in` is sampled on each rising edge of `sclk_in`. The first bit sampled after a frame transition becomes `word_data[23]` and later bits fill downward.
- R3: `word_chan` is 0 for a word received while `lrclk_in` was low (left) and 1 for a word received while it was high (right).
- R4: Each word appears exactly once, as a `word_valid` pulse one system-clock cycle wide. A half that has not reached the capture limit is delivered at the frame transition that ends it. A half that has reached the limit is delivered as soon as the limit is reached.
- R5: A channel half that carries fewer than 24 bits delivers its bits at the top of `word_data`, with zeros below them.
- R6: Bits beyond the 24th in a channel half change neither the delivered word nor the number of words.
- R7: In external mode, the left and right halves of a frame may have different lengths. Each half is received on its own terms.
- R8: In internal mode (`mode_ext`=0), a bit is sampled at the 4th `mclk_en` pulse after a frame transition and at every 8th pulse after that. `sclk_in` is not used.
- R9: In internal mode, `ratio_code` 0 selects 16 bits per half, and the word is delivered after its 16th bit. Codes 1, 2 and 3 select 24, 32 and 32 bits per half. For these codes the word is delivered after the 24th bit and any bits after that are dropped.
- R10: Bits arriving before the first frame transition after reset are discarded and give no word. The frame-line level present at reset is not taken as a transition.
- R11: When a frame transition and a bit-clock rising edge fall in the same cycle, two things happen together. The previous half's pending word is delivered, and the sampled bit becomes the MSB of the new half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ext | input | 1 | 1: external bit clock, 0: internal divided bit clock |
| ratio_code | input | 2 | Detected master-clock/frame ratio: 0=256, 1=384, 2/3=512 |
| mclk_en | input | 1 | One-cycle pulse per master-clock period |
| sclk_in | input | 1 | External serial bit clock |
| lrclk_in | input | 1 | Frame/channel select, low = left |
| sdata_in | input | 1 | Serial audio data |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_chan | output | 1 | Channel of the delivered word, 0 = left |
| word_data | output | 24 | Left-aligned received word |

## Verification
The case where two functions share a cycle is the frame edge that closes a half which has not been delivered yet. In that same cycle the edge both delivers the old word and samples the MSB of the new half on a coinciding bit-clock rise. The bench provokes this by raising `lrclk_in` and `sclk_in` on the same system-clock edge, after halves of 20 and 18 bits, so neither half has reached the limit. It then judges, through the scoreboard, that the pending word comes out intact and that the next word carries the coinciding bit at its top.

// File: rtl/lrj_pkg.sv
package lrj_pkg;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // master clock periods per frame for a ratio code
    function automatic int unsigned ratio_of(input logic [1:0] code);
        case (code)
            2'd0:    return 256;
            2'd1:    return 384;
            default: return 512;
        endcase
    endfunction

endpackage

// File: rtl/lrj_sync.sv
module lrj_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/lrj_bitclk.sv
module lrj_bitclk #(
    parameter int DIV    = 8,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ext,
    input  logic mclk_en,
    input  logic sclk_s,
    input  logic lr_s,
    output logic bit_stb,
    output logic lr_edge
);
    localparam int DIV_W    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int SMP_PH   = DIV / 2 - 1;
    localparam int WARM     = STAGES + 1;
    localparam int WARM_W   = $clog2(WARM + 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              sclk_prev;
        logic              lr_prev;
        logic [WARM_W-1:0] warm;
    } bck_t;

    bck_t q, d;
    logic stb_int, stb_ext;

    always_comb begin
        d            = q;
        d.sclk_prev  = sclk_s;
        d.lr_prev    = lr_s;
        lr_edge      = (q.warm == WARM_W'(WARM)) && (lr_s != q.lr_prev);
        if (q.warm != WARM_W'(WARM)) d.warm = q.warm + WARM_W'(1);
        stb_ext      = sclk_s && !q.sclk_prev;
        stb_int      = mclk_en && (q.div == DIV_W'(SMP_PH)) && !lr_edge;
        if (lr_edge)      d.div = '0;
        else if (mclk_en) d.div = (q.div == DIV_W'(DIV - 1)) ? '0 : q.div + DIV_W'(1);
        bit_stb      = mode_ext ? stb_ext : stb_int;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // a realigned divider cannot sample in the cycle right after the edge
    assert_edge_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_edge && !mode_ext) |=> (mode_ext || !bit_stb));

    // sample points never come in back-to-back cycles in a steady mode
    assert_stb_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> (!bit_stb || !$stable(mode_ext)));
endmodule

// File: rtl/lrj_assembler.sv
module lrj_assembler
    import lrj_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              lr_edge,
    input  logic              lr_lvl,
    input  logic              sdata,
    input  logic [CNT_W-1:0]  cap_len,
    output logic              word_valid,
    output logic              word_chan,
    output logic [WORD_W-1:0] word_data
);
    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        chan_e             half_chan;
        logic              done;
        logic              armed;
        logic              valid;
        chan_e             out_chan;
        logic [WORD_W-1:0] out_data;
    } asm_t;

    asm_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (lr_edge) begin
            if (q.armed && !q.done && (q.cnt != '0)) begin
                d.valid    = 1'b1;
                d.out_data = q.shreg;
                d.out_chan = q.half_chan;
            end
            d.armed     = 1'b1;
            d.shreg     = '0;
            d.cnt       = '0;
            d.done      = 1'b0;
            d.half_chan = chan_e'(lr_lvl);
        end
        if (bit_stb && d.armed && !d.done) begin
            for (int i = 0; i < WORD_W; i++) begin
                if (CNT_W'(i) == d.cnt) d.shreg[WORD_W-1-i] = sdata;
            end
            d.cnt = d.cnt + CNT_W'(1);
            if (d.cnt == cap_len) begin
                d.valid    = 1'b1;
                d.out_data = d.shreg;
                d.out_chan = d.half_chan;
                d.done     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_valid = q.valid;
    assign word_chan  = q.out_chan;
    assign word_data  = q.out_data;

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(WORD_W));

    assert_armed_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> $past(d.armed));

    assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !lr_edge) |=> (q.done && $stable(q.cnt)));
endmodule

// File: rtl/lrj_rx.sv
module lrj_rx
    import lrj_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int MCLK_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ext,
    input  logic [1:0]        ratio_code,
    input  logic              mclk_en,
    input  logic              sclk_in,
    input  logic              lrclk_in,
    input  logic              sdata_in,
    output logic              word_valid,
    output logic              word_chan,
    output logic [WORD_W-1:0] word_data
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [2:0]       sync_o;
    logic             sclk_s, lr_s, sdata_s;
    logic             bit_stb, lr_edge;
    logic [CNT_W-1:0] cap_len;
    int unsigned      bits_half;

    lrj_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sclk_in, lrclk_in, sdata_in}),
        .dout  (sync_o)
    );
    assign {sclk_s, lr_s, sdata_s} = sync_o;

    lrj_bitclk #(.DIV(MCLK_DIV), .STAGES(SYNC_STAGES)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_ext (mode_ext),
        .mclk_en  (mclk_en),
        .sclk_s   (sclk_s),
        .lr_s     (lr_s),
        .bit_stb  (bit_stb),
        .lr_edge  (lr_edge)
    );

    always_comb begin
        bits_half = ratio_of(ratio_code) / (2 * MCLK_DIV);
        if (mode_ext || bits_half >= WORD_W) cap_len = CNT_W'(WORD_W);
        else                                 cap_len = CNT_W'(bits_half);
    end

    lrj_assembler #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .lr_edge    (lr_edge),
        .lr_lvl     (lr_s),
        .sdata      (sdata_s),
        .cap_len    (cap_len),
        .word_valid (word_valid),
        .word_chan  (word_chan),
        .word_data  (word_data)
    );
endmodule

// File: tb/lrj_rx_tb_top.sv
module lrj_rx_tb_top;
    localparam int W = 24;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, mode_ext, sclk_in, lrclk_in, sdata_in, mclk_run;
    logic mclk_en = 1'b0;
    logic [1:0] ratio_code;
    logic word_valid, word_chan;
    logic [W-1:0] word_data;

    int n_cmp = 0, n_bad = 0;
    logic [W:0] exp_q[$];
    string      tag_q[$];
    bit         done_flag = 0;

    lrj_rx dut_i (
        .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .ratio_code(ratio_code),
        .mclk_en(mclk_en), .sclk_in(sclk_in), .lrclk_in(lrclk_in), .sdata_in(sdata_in),
        .word_valid(word_valid), .word_chan(word_chan), .word_data(word_data)
    );

    always @(negedge clk) mclk_en <= mclk_run ? ~mclk_en : 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] expect_word(input logic [31:0] bits, input int n);
        logic [W-1:0] m;
        m = (n >= W) ? '1 : ~({W{1'b1}} >> n);
        return bits[31:8] & m;
    endfunction

    task automatic push(input logic lr, input logic [31:0] bits, input int n, input string tag);
        exp_q.push_back({lr, expect_word(bits, n)});
        tag_q.push_back(tag);
    endtask

    // monitor: pops the scoreboard as words come out
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            logic [W:0] e;
            string t;
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R4 actual=unexpected word %h expected=no word", {word_chan, word_data});
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {7'd0, word_chan, word_data}, {7'd0, e});
            end
        end
    end

    // external-clock half: 8 system cycles per bit, rise after 4
    task automatic ext_half(input logic lr, input int nbits, input logic [31:0] bits,
                            input bit coincide, input bit expect_it, input string tag);
        if (expect_it) push(lr, bits, nbits, tag);
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            sdata_in = bits[31-k];
            sclk_in  = 1'b0;
            if (k == 0 && !coincide) lrclk_in = lr;
            repeat (3) @(negedge clk);
            @(negedge clk);
            sclk_in = 1'b1;
            if (k == 0 && coincide) lrclk_in = lr;
            repeat (3) @(negedge clk);
        end
    endtask

    // internal-clock half: 16 system cycles (8 mclk pulses) per bit
    task automatic int_half(input logic lr, input int nbits, input int cap,
                            input logic [31:0] bits, input string tag);
        push(lr, bits, (nbits < cap) ? nbits : cap, tag);
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            if (k == 0) lrclk_in = lr;
            sdata_in = bits[31-k];
            repeat (15) @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic ext, input logic lr);
        rst_n = 1'b0; mode_ext = ext; lrclk_in = lr; sclk_in = 1'b0; sdata_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 valid", {31'd0, word_valid}, 32'd0);
        chk("R1 data", {8'd0, word_data}, 32'd0);
        chk("R1 chan", {31'd0, word_chan}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", {31'd0, word_valid}, 32'd0);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        mclk_run = 1'b0; ratio_code = 2'd0;
        // ---------- external bit clock ----------
        do_reset(1'b1, 1'b1);
        // R10: bits with no frame transition yet are dropped
        ext_half(1'b1, 8, 32'hFFFF_FFFF, 1'b0, 1'b0, "R10");
        ext_half(1'b0, 24, 32'hA5C3_E100, 1'b0, 1'b1, "R2 R3 left 24");
        ext_half(1'b1, 24, 32'h1234_5600, 1'b0, 1'b1, "R3 right 24");
        ext_half(1'b0, 16, 32'hBEEF_0000, 1'b0, 1'b1, "R5 short 16");
        ext_half(1'b1, 28, 32'h8765_4321, 1'b0, 1'b1, "R6 R7 long 28");
        ext_half(1'b0, 20, 32'hF0F0_F000, 1'b0, 1'b1, "R7 left 20");
        ext_half(1'b1, 18, 32'hC0DE_C000, 1'b1, 1'b1, "R11 coincide right");
        ext_half(1'b0, 24, 32'h7E57_AB00, 1'b1, 1'b1, "R11 coincide left");
        ext_half(1'b1, 1, 32'h8000_0000, 1'b0, 1'b1, "R5 single bit");
        @(negedge clk); lrclk_in = 1'b0;
        repeat (20) @(negedge clk);
        chk("R4 ext words pending", exp_q.size(), 0);

        // ---------- internal bit clock ----------
        do_reset(1'b0, 1'b0);
        mclk_run = 1'b1;
        sdata_in = 1'b1;
        repeat (600) @(negedge clk);
        chk("R10 internal no word before edge", exp_q.size(), 0);
        ratio_code = 2'd0;
        int_half(1'b1, 16, 16, 32'hABCD_0000, "R8 R9 ratio256 right");
        int_half(1'b0, 16, 16, 32'h1357_0000, "R8 R9 ratio256 left");
        ratio_code = 2'd1;
        int_half(1'b1, 24, 24, 32'h9A8B_7C00, "R8 R9 ratio384 right");
        int_half(1'b0, 24, 24, 32'h0F1E_2D00, "R8 R9 ratio384 left");
        ratio_code = 2'd2;
        int_half(1'b1, 32, 24, 32'hDEAD_BEEF, "R6 R9 ratio512 right");
        int_half(1'b0, 32, 24, 32'h5A5A_A5A5, "R6 R9 ratio512 left");
        ratio_code = 2'd3;
        int_half(1'b1, 32, 24, 32'h3C3C_FFFF, "R9 code3 right");
        @(negedge clk); lrclk_in = 1'b0; sdata_in = 1'b0;
        repeat (300) @(negedge clk);
        chk("R4 int words pending", exp_q.size(), 0);
        done_flag = 1;
        report();
    end
endmodule